// File: doc/BRIEF.md
# One's Complement End-Around-Carry Adder

This block adds two signed integers held in one's complement (inverse) code. Each word is N bits wide. The top bit is the sign, 0 for positive and 1 for negative, and the lower N-1 bits carry the magnitude. Negative values are the bitwise inverse of their positive counterparts.

The datapath is a ripple chain of one-bit full-adder cells. Every cell is written as a network of two-input NAND gates, not as an arithmetic operator. The carry out of the sign position must wrap back into the least significant position. To do this without a combinational loop, the block runs two ripple passes:

- The first pass adds the operands with a carry-in of zero.
- The second pass adds that first-pass carry-out to the raw sum. This pass can never produce a carry of its own.

The result leaves together with an overflow flag and a flag that marks minus zero (all ones). Minus zero is reported as it is and is not folded to plus zero.

Operands enter through a valid/ready handshake, and results leave through a second one:

- An input word is taken in on a rising clock edge when `in_valid` and `in_ready` are both high.
- With the register stage enabled (`REG_OUT`=1), the result appears one cycle later.
- A result that has not been taken stays on the outputs, unchanged, until `out_ready` is seen high.
- While a result is held, `in_ready` stays low, so back-pressure reaches the producer in the same cycle.
- With `REG_OUT`=0 the block is purely combinational. In that case `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`.

The width parameter N counts the sign bit and must be at least 2.

Top module: `oc_eac_adder`

## Requirements
- R1: For any two N-bit one's complement operands, `out_sum` equals the low N bits of a+b, plus the carry out of bit N-1 added back at bit 0 (end-around carry).
- R2: With N=5, operands 01011 and 10110 give 00010 (raw sum 00001 with a wrapped carry of 1).
- R3: `out_ovf` is 1 exactly when both operand sign bits (bit N-1) are equal and the result sign bit differs from them. Overflow and minus zero are never flagged together.
- R4: `out_negzero` is 1 exactly when `out_sum` is all ones. An operand added to its bitwise inverse gives all ones and sets the flag. The result is not normalised to all zeros.
- R5: The wrapped carry is added exactly once. Minus zero (11111) plus one (00001) gives 00001 for N=5, and the second pass never carries out.
- R6: With `REG_OUT`=1, an accepted input shows on the outputs with `out_valid`=1 on the next cycle. While `out_ready` is 0, `out_valid` and all result bits hold. After a handshake with no new input, `out_valid` returns to 0.
- R7: With `REG_OUT`=1, `in_ready` is 1 when no result is held or when `out_ready` is 1, and 0 otherwise. Every accepted input yields exactly one result, in order.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.
- R9: With `REG_OUT`=0, the result and flags follow the operands in the same cycle, `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take the operand pair |
| in_a | input | N | First operand, one's complement |
| in_b | input | N | Second operand, one's complement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | N | Sum, one's complement |
| out_ovf | output | 1 | Signed overflow |
| out_negzero | output | 1 | Sum is all ones (minus zero) |

## Verification
The bench targets three cases:

- **Wrap-around.** It sweeps every operand pair at N=5, plus the stated worked example. A design that dropped the wrapped carry would be off by one on every sum whose sign position carried. A design that added the carry twice, or at the wrong weight, would break the minus-zero plus one case.
- **Flags.** Overflow is probed at both extremes, positive and negative. Minus zero is produced both by an operand and its inverse and by a sum through the wrap. A design that normalised minus zero to zero, or took overflow from the carry, would miscompare there.
- **Handshake.** Random back-pressure on the result side checks that held results stay stable and that no result is lost or repeated.

A second, combinational instance at N=16 takes random and edge-value vectors.

// File: rtl/oc_eac_pkg.sv
`timescale 1ns/1ps
package oc_eac_pkg;

  // Base gate: the only primitive used in the adder cells.
  function automatic logic nand2(input logic a, input logic b);
    return ~(a & b);
  endfunction

  // Inverter as a NAND with tied inputs.
  function automatic logic inv1(input logic a);
    return nand2(a, a);
  endfunction

  // Two-input AND as NAND followed by a NAND inverter.
  function automatic logic and2(input logic a, input logic b);
    logic n;
    n = nand2(a, b);
    return nand2(n, n);
  endfunction

  // Three-input NAND composed from two-input NANDs.
  function automatic logic nand3(input logic a, input logic b, input logic c);
    return nand2(and2(a, b), c);
  endfunction

  // Four-input NAND composed from two-input NANDs.
  function automatic logic nand4(input logic a, input logic b,
                                 input logic c, input logic d);
    return nand2(and2(a, b), and2(c, d));
  endfunction

endpackage

// File: rtl/oc_fa_cell.sv
`timescale 1ns/1ps
module oc_fa_cell
  import oc_eac_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  logic xn, yn, cn;
  logic m0, m1, m2, m3;   // inverted minterms of the odd-parity function
  logic p0, p1, p2;       // inverted pair products of the majority function

  assign xn = inv1(x);
  assign yn = inv1(y);
  assign cn = inv1(ci);

  // Sum: four-term sum of products rewritten as NAND of NANDs.
  assign m0 = nand3(xn, yn, ci);
  assign m1 = nand3(xn, y,  cn);
  assign m2 = nand3(x,  yn, cn);
  assign m3 = nand3(x,  y,  ci);
  assign s  = nand4(m0, m1, m2, m3);

  // Carry: minimal majority form x.y + x.c + y.c as NAND of NANDs.
  assign p0 = nand2(x, y);
  assign p1 = nand2(x, ci);
  assign p2 = nand2(y, ci);
  assign co = nand3(p0, p1, p2);

endmodule

// File: rtl/oc_ripple_chain.sv
`timescale 1ns/1ps
module oc_ripple_chain #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);

  logic [N:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < N; i++) begin : g_cell
    oc_fa_cell u_cell (
      .x  (a[i]),
      .y  (b[i]),
      .ci (carry[i]),
      .s  (sum[i]),
      .co (carry[i+1])
    );
  end

  assign cout = carry[N];

endmodule

// File: rtl/oc_out_stage.sv
`timescale 1ns/1ps
module oc_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  if (REG_OUT) begin : g_reg
    logic         valid_q;
    logic [W-1:0] data_q;
    logic         take;

    assign in_ready = ~valid_q | out_ready;
    assign take     = in_valid & in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        data_q  <= '0;
      end else begin
        if (take) begin
          data_q <= in_data;
        end
        if (take) begin
          valid_q <= 1'b1;
        end else if (out_ready) begin
          valid_q <= 1'b0;
        end
      end
    end

    assign out_valid = valid_q;
    assign out_data  = data_q;

    // R6: a held result keeps its value until the consumer takes it
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6: an accepted word is presented on the next cycle
    assert_accept_shows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    // R7: back-pressure only while a result is waiting and not taken
    assert_ready_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (out_valid && !out_ready));
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end

endmodule

// File: rtl/oc_eac_adder.sv
`timescale 1ns/1ps
module oc_eac_adder #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_sum,
  output logic         out_ovf,
  output logic         out_negzero
);

  localparam int W    = N + 2;
  localparam int SGN  = N - 1;

  logic [N-1:0] raw_sum;
  logic         wrap;
  logic [N-1:0] fin_sum;
  logic         spill;
  logic         ovf_c;
  logic         negz_c;
  logic [W-1:0] pay_in;
  logic [W-1:0] pay_out;

  // First pass: operands with no carry in.
  oc_ripple_chain #(.N(N)) u_pass1 (
    .a    (in_a),
    .b    (in_b),
    .cin  (1'b0),
    .sum  (raw_sum),
    .cout (wrap)
  );

  // Second pass: fold the sign carry back into the least significant bit.
  oc_ripple_chain #(.N(N)) u_pass2 (
    .a    (raw_sum),
    .b    ({N{1'b0}}),
    .cin  (wrap),
    .sum  (fin_sum),
    .cout (spill)
  );

  assign ovf_c  = (in_a[SGN] == in_b[SGN]) && (fin_sum[SGN] != in_a[SGN]);
  assign negz_c = &fin_sum;

  assign pay_in = {ovf_c, negz_c, fin_sum};

  oc_out_stage #(.W(W), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign out_sum     = pay_out[N-1:0];
  assign out_negzero = pay_out[N];
  assign out_ovf     = pay_out[N+1];

  // R5: the folded carry never produces a second wrap
  assert_single_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !spill);

  // R1: without a sign carry the second pass leaves the raw sum untouched
  assert_no_wrap_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wrap) |-> (fin_sum == raw_sum));

  // R3: overflow and minus zero exclude each other
  assert_ovf_excl_negzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !(ovf_c && negz_c));

  // R4: an operand plus its inverse lands on minus zero
  assert_inverse_negzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_a == ~in_b)) |-> negz_c);

endmodule

// File: tb/tb_oc_eac_adder.sv
`timescale 1ns/1ps
module tb_oc_eac_adder;

  localparam int CLK_PERIOD = 10;
  localparam int NA = 5;
  localparam int NB = 16;
  localparam int WATCHDOG = 150000;

  typedef struct {
    logic [NA-1:0] s;
    logic          ov;
    logic          nz;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic          a_in_valid = 1'b0;
  logic          a_in_ready;
  logic [NA-1:0] a_in_a = '0;
  logic [NA-1:0] a_in_b = '0;
  logic          a_out_valid;
  logic          a_out_ready = 1'b0;
  logic [NA-1:0] a_out_sum;
  logic          a_out_ovf;
  logic          a_out_nz;

  logic          b_in_valid = 1'b0;
  logic          b_in_ready;
  logic [NB-1:0] b_in_a = '0;
  logic [NB-1:0] b_in_b = '0;
  logic          b_out_valid;
  logic [NB-1:0] b_out_sum;
  logic          b_out_ovf;
  logic          b_out_nz;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   mon_on   = 1'b0;
  bit   done     = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_eac_adder #(.N(NA), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(a_in_valid), .in_ready(a_in_ready),
    .in_a(a_in_a), .in_b(a_in_b),
    .out_valid(a_out_valid), .out_ready(a_out_ready),
    .out_sum(a_out_sum), .out_ovf(a_out_ovf), .out_negzero(a_out_nz)
  );

  oc_eac_adder #(.N(NB), .REG_OUT(1'b0)) dut_w (
    .clk(clk), .rst_n(rst_n),
    .in_valid(b_in_valid), .in_ready(b_in_ready),
    .in_a(b_in_a), .in_b(b_in_b),
    .out_valid(b_out_valid), .out_ready(1'b1),
    .out_sum(b_out_sum), .out_ovf(b_out_ovf), .out_negzero(b_out_nz)
  );

  // Behavioural one's complement reference: {ovf, negzero, sum}.
  function automatic logic [17:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                          input int w);
    logic [16:0] full;
    logic [15:0] mask, r;
    logic        ov, nz;
    mask = 16'hFFFF >> (16 - w);
    full = {1'b0, a & mask} + {1'b0, b & mask};
    r    = 16'((full + 17'(full[w])) & {1'b0, mask});
    ov   = (a[w-1] == b[w-1]) && (r[w-1] != a[w-1]);
    nz   = (r == mask);
    return {ov, nz, r};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Driver: offers one word to the registered instance and logs its expectation.
  task automatic send5(input logic [NA-1:0] a, input logic [NA-1:0] b, input string tag);
    logic [17:0] r;
    exp_t e;
    @(negedge clk);
    a_in_a = a; a_in_b = b; a_in_valid = 1'b1;
    #1;
    while (!a_in_ready) begin
      @(negedge clk);
      #1;
    end
    r = ref_add(16'(a), 16'(b), NA);
    e.s = r[NA-1:0]; e.ov = r[17]; e.nz = r[16]; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
  endtask

  // Monitor: random back-pressure, pops and compares every delivered result.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        a_out_ready = ($urandom_range(0, 3) != 0);
        #1;
        if (a_out_valid && a_out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R7 extra result", 32'(a_out_sum), 32'h0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(a_out_sum == e.s, {e.tag, " sum"}, 32'(a_out_sum), 32'(e.s));
            check(a_out_ovf == e.ov, "R3 ovf", 32'(a_out_ovf), 32'(e.ov));
            check(a_out_nz == e.nz, "R4 negzero", 32'(a_out_nz), 32'(e.nz));
          end
        end
      end
    end
  end

  // Combinational wide instance check (R9 plus value checks).
  task automatic apply16(input logic [NB-1:0] a, input logic [NB-1:0] b, input string tag);
    logic [17:0] r;
    @(negedge clk);
    b_in_a = a; b_in_b = b; b_in_valid = 1'b1;
    #1;
    r = ref_add(a, b, NB);
    check(b_out_sum == r[15:0], {tag, " wide sum"}, 32'(b_out_sum), 32'(r[15:0]));
    check(b_out_ovf == r[17], "R3 wide ovf", 32'(b_out_ovf), 32'(r[17]));
    check(b_out_nz == r[16], "R4 wide negzero", 32'(b_out_nz), 32'(r[16]));
    check(b_out_valid == 1'b1 && b_in_ready == 1'b1, "R9 handshake follow",
          32'({b_out_valid, b_in_ready}), 32'h3);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(a_out_valid == 1'b0, "R8 out_valid after reset", 32'(a_out_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(a_out_valid == 1'b0 && a_in_ready == 1'b1, "R8 idle after reset",
          32'({a_out_valid, a_in_ready}), 32'h1);

    // R6/R7 directed: hold under back-pressure, with the worked example (R2).
    a_out_ready = 1'b0;
    @(negedge clk);
    a_in_a = 5'b01011; a_in_b = 5'b10110; a_in_valid = 1'b1;
    #1;
    check(a_in_ready == 1'b1, "R7 ready when empty", 32'(a_in_ready), 32'h1);
    @(posedge clk);
    @(negedge clk);
    a_in_valid = 1'b0;
    #1;
    check(a_out_valid == 1'b1, "R6 valid next cycle", 32'(a_out_valid), 32'h1);
    check(a_out_sum == 5'b00010, "R2 worked example", 32'(a_out_sum), 32'h02);
    check(a_in_ready == 1'b0, "R7 back-pressure", 32'(a_in_ready), 32'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      check(a_out_valid == 1'b1 && a_out_sum == 5'b00010, "R6 hold stable",
            32'({a_out_valid, a_out_sum}), 32'h22);
    end
    a_out_ready = 1'b1;
    #1;
    check(a_in_ready == 1'b1, "R7 ready on take", 32'(a_in_ready), 32'h1);
    @(posedge clk);
    @(negedge clk);
    #1;
    check(a_out_valid == 1'b0, "R6 drains", 32'(a_out_valid), 32'h0);

    // Scoreboarded traffic with random back-pressure.
    mon_on = 1'b1;
    send5(5'b01011, 5'b10110, "R2");
    send5(5'b01111, 5'b00001, "R3");
    send5(5'b10000, 5'b11110, "R3");
    send5(5'b01010, 5'b10101, "R4");
    send5(5'b11111, 5'b11111, "R4");
    send5(5'b11111, 5'b00001, "R5");
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 32; j++) begin
        send5(5'(i), 5'(j), "R1");
      end
    end
    @(negedge clk);
    a_in_valid = 1'b0;
    for (int k = 0; k < 200 && sb.size() != 0; k++) @(negedge clk);
    check(sb.size() == 0, "R7 all results delivered", 32'(sb.size()), 32'h0);
    mon_on = 1'b0;

    // Wide combinational instance.
    apply16(16'h7FFF, 16'h0001, "R3");
    apply16(16'h8000, 16'hFFFF, "R5");
    apply16(16'h1234, 16'hEDCB, "R4");
    apply16(16'hFFFF, 16'h0001, "R5");
    for (int i = 0; i < 2000; i++) begin
      apply16(16'($urandom), 16'($urandom), "R1");
    end
    @(negedge clk);
    b_in_valid = 1'b0;
    #1;
    check(b_out_valid == 1'b0, "R9 valid follows low", 32'(b_out_valid), 32'h0);

    done = 1'b1;
    finish_run();
  end

endmodule